// File: doc/BRIEF.md
# EEPROM Write Guard and Busy-Status Controller

This block is the device-side control logic of a byte-wide EEPROM model, clocked by one sampling clock. It takes active-low chip-enable, output-enable and write-enable strobes, a digital supply-good flag, and address and data buses. It decides whether each write-enable pulse is a real write, and it collects accepted bytes into a page buffer. It then runs a programming interval and finally commits the page into a behavioural storage array.

The block rejects a write in three cases: the write-enable low pulse is too short, the supply-good flag is low, or the strobes are in an inhibiting state. While a write is loading or programming, every read returns a status byte. Its top bit is the complement of bit 7 of the most recently loaded byte, and all its other bits are zero. Software can therefore poll any address until the real data returns.

All strobes, the supply flag and the buses pass through a two-stage synchronizer. Read data comes out registered, together with an output-enable flag.

Top module: `eeprom_wguard`

## Requirements
- R1: A write-enable low pulse shorter than MIN_LOW clock cycles starts no write. A pulse of exactly MIN_LOW cycles is accepted.
- R2: While pwr_ok is low at any point of the write-enable low pulse, or at its rising edge, the write is rejected.
- R3: A write is rejected if, during the low pulse or at its rising edge, ce_n is high or oe_n is low.
- R4: The address is captured when write-enable falls. The data is captured when write-enable rises.
- R5: From an accepted byte until its page is committed, a read (ce_n=0, oe_n=0, we_n=1) returns a status byte. Bit DW-1 is the complement of bit 7 of the last loaded byte, and bits DW-2..0 are zero.
- R6: After the load window of LOAD_WIN idle cycles, a programming interval of PROG_CYC cycles follows, then a commit of one cycle per page slot. Reads then return the stored byte unchanged.
- R7: Bytes accepted within LOAD_WIN cycles of each other form one page. Their upper address bits (above PAGE_AW) come from the first byte, and their low PAGE_AW bits select the slot. Slots that were not loaded keep their old contents.
- R8: Write attempts during the programming interval or the commit are ignored. They change neither the stored data nor the status bit.
- R9: Reset fills the whole array with all ones, one location per cycle, and the block is busy during this fill.
- R10: A second byte to the same page slot within one page replaces the first.
- R11: dout_oe is high only for a read cycle, and dout is zero when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sampling clock |
| rst | input | 1 | synchronous active-high reset |
| ce_n | input | 1 | chip enable, active low |
| oe_n | input | 1 | output enable, active low |
| we_n | input | 1 | write enable, active low |
| pwr_ok | input | 1 | supply-good flag, high when supply is adequate |
| addr | input | AW | byte address |
| din | input | DW | write data |
| dout | output | DW | registered read data or status byte |
| dout_oe | output | 1 | read data valid and driven |

## Verification
The bench sends write-enable pulses one cycle below the width threshold and exactly at it. A design with an off-by-one counter would either program from a glitch or drop a legitimate byte. It changes the address and the data while write-enable is low, which exposes a design that captures both on the same edge. It also loads a page that includes an address outside the first byte's page, which the controller must fold into the first byte's page rather than spill into a neighbouring page. Finally, it writes during programming and checks that neither the stored data nor the polled status bit moves, as they would if the controller reopened its page buffer.

// File: rtl/eg_pkg.sv
package eg_pkg;
  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_LOAD,
    ST_PROG,
    ST_COMMIT
  } eg_state_e;
endpackage

// File: rtl/eg_strobe_qual.sv
module eg_strobe_qual #(
  parameter int AW      = 6,
  parameter int DW      = 8,
  parameter int MIN_LOW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          pwr_ok,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_acc,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr
);
  localparam int CW = $clog2(MIN_LOW + 1);

  logic          ce_m, ce_s, oe_m, oe_s, we_m, we_s, pw_m, pw_s, we_prev;
  logic [AW-1:0] addr_m, addr_s, a_lat;
  logic [DW-1:0] din_m, din_s;
  logic          armed;
  logic [CW-1:0] lowcnt;
  logic          gate_ok, we_fall, we_rise;

  // two-stage synchronizer for every input
  always_ff @(posedge clk) begin
    if (rst) begin
      ce_m <= 1'b1; ce_s <= 1'b1;
      oe_m <= 1'b1; oe_s <= 1'b1;
      we_m <= 1'b1; we_s <= 1'b1; we_prev <= 1'b1;
      pw_m <= 1'b0; pw_s <= 1'b0;
      addr_m <= '0; addr_s <= '0;
      din_m <= '0;  din_s <= '0;
    end else begin
      ce_m <= ce_n;   ce_s <= ce_m;
      oe_m <= oe_n;   oe_s <= oe_m;
      we_m <= we_n;   we_s <= we_m; we_prev <= we_s;
      pw_m <= pwr_ok; pw_s <= pw_m;
      addr_m <= addr; addr_s <= addr_m;
      din_m <= din;   din_s <= din_m;
    end
  end

  assign gate_ok = ~ce_s & oe_s & pw_s;
  assign we_fall = we_prev & ~we_s;
  assign we_rise = ~we_prev & we_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      lowcnt  <= '0;
      a_lat   <= '0;
      wr_acc  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_acc <= 1'b0;
      if (we_fall) begin
        armed  <= gate_ok;
        lowcnt <= CW'(1);
        a_lat  <= addr_s;
      end else if (!we_s) begin
        if (!gate_ok) armed <= 1'b0;
        if (lowcnt != CW'(MIN_LOW)) lowcnt <= lowcnt + CW'(1);
      end else if (we_rise) begin
        wr_acc  <= armed & gate_ok & (lowcnt >= CW'(MIN_LOW));
        wr_addr <= a_lat;
        wr_data <= din_s;
        armed   <= 1'b0;
      end
    end
  end

  assign rd_req  = ~ce_s & ~oe_s & we_s;
  assign rd_addr = addr_s;

  // R4: an accepted write always follows a write-enable rising edge
  p_acc_after_rise_r4: assert property (@(posedge clk) disable iff (rst)
    wr_acc |-> ($past(we_s) && !$past(we_prev)));

  // R2: supply must have been good when the write was taken
  p_acc_needs_pwr_r2: assert property (@(posedge clk) disable iff (rst)
    wr_acc |-> $past(pw_s));
endmodule

// File: rtl/eg_seq.sv
module eg_seq
  import eg_pkg::*;
#(
  parameter int AW       = 6,
  parameter int DW       = 8,
  parameter int PAGE_AW  = 2,
  parameter int LOAD_WIN = 24,
  parameter int PROG_CYC = 1400000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_acc,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          stat_d7
);
  localparam int PAGE = 1 << PAGE_AW;
  localparam int BW   = AW - PAGE_AW;
  localparam int WCW  = $clog2(LOAD_WIN + 1);
  localparam int PCW  = $clog2(PROG_CYC + 1);

  eg_state_e          st;
  logic [AW-1:0]      sweep;
  logic [PAGE_AW-1:0] cidx;
  logic [WCW-1:0]     wcnt;
  logic [PCW-1:0]     pcnt;
  logic [BW-1:0]      pg_base;
  logic [PAGE-1:0]    pg_vld;
  logic [DW-1:0]      pg_data [PAGE];
  logic [PAGE_AW-1:0] off;

  assign off = wr_addr[PAGE_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_INIT;
      sweep   <= '0;
      cidx    <= '0;
      wcnt    <= '0;
      pcnt    <= '0;
      pg_base <= '0;
      pg_vld  <= '0;
      stat_d7 <= 1'b0;
      for (int i = 0; i < PAGE; i++) pg_data[i] <= '0;
    end else begin
      case (st)
        ST_INIT: begin
          sweep <= sweep + AW'(1);
          if (sweep == AW'(PAGE * (1 << BW) - 1)) st <= ST_IDLE;
        end
        ST_IDLE: begin
          if (wr_acc) begin
            pg_base      <= wr_addr[AW-1:PAGE_AW];
            pg_data[off] <= wr_data;
            pg_vld       <= PAGE'(1) << off;
            stat_d7      <= wr_data[DW-1];
            wcnt         <= '0;
            st           <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (wr_acc) begin
            pg_data[off] <= wr_data;
            pg_vld[off]  <= 1'b1;
            stat_d7      <= wr_data[DW-1];
            wcnt         <= '0;
          end else if (wcnt == WCW'(LOAD_WIN - 1)) begin
            pcnt <= '0;
            st   <= ST_PROG;
          end else begin
            wcnt <= wcnt + WCW'(1);
          end
        end
        ST_PROG: begin
          if (pcnt == PCW'(PROG_CYC - 1)) begin
            cidx <= '0;
            st   <= ST_COMMIT;
          end else begin
            pcnt <= pcnt + PCW'(1);
          end
        end
        ST_COMMIT: begin
          if (cidx == PAGE_AW'(PAGE - 1)) begin
            pg_vld <= '0;
            st     <= ST_IDLE;
          end else begin
            cidx <= cidx + PAGE_AW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = '0;
    mem_wdata = '0;
    if (st == ST_INIT) begin
      mem_we    = 1'b1;
      mem_waddr = sweep;
      mem_wdata = '1;
    end else if (st == ST_COMMIT) begin
      mem_we    = pg_vld[cidx];
      mem_waddr = {pg_base, cidx};
      mem_wdata = pg_data[cidx];
    end
  end

  assign busy = (st != ST_IDLE);

  // R8: status bit frozen while programming
  p_status_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PROG && $past(st == ST_PROG)) |-> $stable(stat_d7));

  // R6: commit is entered only from the programming interval
  p_commit_after_prog_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COMMIT && !$past(st == ST_COMMIT)) |-> $past(st == ST_PROG));

  // R7: a loading page always holds at least one byte
  p_page_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOAD) |-> (pg_vld != '0));
endmodule

// File: rtl/eg_store.sv
module eg_store #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eeprom_wguard.sv
module eeprom_wguard #(
  parameter int AW       = 6,
  parameter int DW       = 8,
  parameter int PAGE_AW  = 2,
  parameter int MIN_LOW  = 3,
  parameter int LOAD_WIN = 24,
  parameter int PROG_CYC = 1400000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          pwr_ok,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe
);
  logic          wr_acc, rd_req, rd_req_d;
  logic [AW-1:0] wr_addr, rd_addr, mem_waddr;
  logic [DW-1:0] wr_data, mem_wdata, ram_q;
  logic          mem_we, busy, stat_d7;

  eg_strobe_qual #(.AW(AW), .DW(DW), .MIN_LOW(MIN_LOW)) u_qual (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .pwr_ok(pwr_ok), .addr(addr), .din(din),
    .wr_acc(wr_acc), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr)
  );

  eg_seq #(.AW(AW), .DW(DW), .PAGE_AW(PAGE_AW), .LOAD_WIN(LOAD_WIN),
           .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst(rst), .wr_acc(wr_acc), .wr_addr(wr_addr),
    .wr_data(wr_data), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .busy(busy), .stat_d7(stat_d7)
  );

  eg_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req_d <= 1'b0;
      dout     <= '0;
      dout_oe  <= 1'b0;
    end else begin
      rd_req_d <= rd_req;
      dout_oe  <= rd_req_d;
      if (!rd_req_d) dout <= '0;
      else if (busy) dout <= {~stat_d7, {(DW-1){1'b0}}};
      else dout <= ram_q;
    end
  end

  // R5: status byte has zero low bits and the inverted stored bit 7
  p_status_low_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (dout_oe && $past(busy)) |-> (dout[DW-2:0] == '0));
  p_status_top_r5: assert property (@(posedge clk) disable iff (rst)
    (dout_oe && $past(busy)) |-> (dout[DW-1] == ~$past(stat_d7)));
  // R11: quiet output bus outside reads
  p_quiet_bus_r11: assert property (@(posedge clk) disable iff (rst)
    !dout_oe |-> (dout == '0));
endmodule

// File: tb/eeprom_wguard_tb_top.sv
`timescale 1ns/1ps
module eeprom_wguard_tb_top;
  localparam int AW = 6, DW = 8, PAGE_AW = 2, MIN_LOW = 3;
  localparam int LOAD_WIN = 24, PROG_CYC = 200;
  localparam int IDLE_WAIT = LOAD_WIN + PROG_CYC + (1 << PAGE_AW) + 30;

  logic clk = 1'b0, rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pwr_ok = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_oe;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  eeprom_wguard #(.AW(AW), .DW(DW), .PAGE_AW(PAGE_AW), .MIN_LOW(MIN_LOW),
                  .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .pwr_ok(pwr_ok), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input string req, input logic [DW-1:0] got,
                     input logic [DW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // mode 0 normal, 1 oe low, 2 ce high, 3 change addr/data mid-pulse
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input int len, input int mode);
    @(negedge clk);
    addr = a; din = (mode == 3) ? ~d : d;
    ce_n = (mode == 2); oe_n = (mode != 1); we_n = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (mode == 3 && i == 0) addr = a + AW'(1);
    end
    we_n = 1'b1; din = d;
    cyc(2);
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(1);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] q,
                    output logic oe);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    cyc(6);
    q = dout; oe = dout_oe;
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(2);
  endtask

  task automatic t_reset();
    logic [DW-1:0] q; logic oe;
    chk("R11 idle oe", {7'b0, dout_oe}, 8'h00);
    chk("R11 idle bus", dout, 8'h00);
    rd(6'd0, q, oe);  chk("R9 addr0", q, 8'hFF); chk("R11 read oe", {7'b0, oe}, 8'h01);
    rd(6'd37, q, oe); chk("R9 addr37", q, 8'hFF);
    rd(6'd63, q, oe); chk("R9 addr63", q, 8'hFF);
  endtask

  task automatic t_short();
    logic [DW-1:0] q; logic oe;
    wr(6'd5, 8'h12, MIN_LOW - 1, 0);
    rd(6'd5, q, oe); chk("R1 short pulse rejected", q, 8'hFF);
    wr(6'd5, 8'h12, MIN_LOW, 0);
    rd(6'd5, q, oe); chk("R1 min pulse busy", q, 8'h80);
    cyc(IDLE_WAIT);
    rd(6'd5, q, oe); chk("R1 min pulse stored", q, 8'h12);
  endtask

  task automatic t_pwr();
    logic [DW-1:0] q; logic oe;
    pwr_ok = 1'b0;
    wr(6'd9, 8'h34, 5, 0);
    pwr_ok = 1'b1;
    rd(6'd9, q, oe); chk("R2 low supply blocked", q, 8'hFF);
  endtask

  task automatic t_inhibit();
    logic [DW-1:0] q; logic oe;
    wr(6'd12, 8'h56, 5, 1);
    rd(6'd12, q, oe); chk("R3 oe low inhibits", q, 8'hFF);
    wr(6'd13, 8'h57, 5, 2);
    rd(6'd13, q, oe); chk("R3 ce high inhibits", q, 8'hFF);
  endtask

  task automatic t_latch();
    logic [DW-1:0] q; logic oe;
    wr(6'd16, 8'h5A, 5, 3);
    cyc(IDLE_WAIT);
    rd(6'd16, q, oe); chk("R4 addr at fall data at rise", q, 8'h5A);
    rd(6'd17, q, oe); chk("R4 later addr untouched", q, 8'hFF);
  endtask

  task automatic t_status();
    logic [DW-1:0] q; logic oe;
    wr(6'd20, 8'hAA, 4, 0);
    rd(6'd20, q, oe); chk("R5 status d7=1", q, 8'h00);
    cyc(LOAD_WIN + PROG_CYC / 2);
    rd(6'd3, q, oe); chk("R5 status mid-program any addr", q, 8'h00);
    cyc(IDLE_WAIT);
    rd(6'd20, q, oe); chk("R6 data after program", q, 8'hAA);
    wr(6'd21, 8'h2B, 4, 0);
    rd(6'd21, q, oe); chk("R5 status d7=0", q, 8'h80);
    cyc(IDLE_WAIT);
    rd(6'd21, q, oe); chk("R6 second byte stored", q, 8'h2B);
  endtask

  task automatic t_page();
    logic [DW-1:0] q; logic oe;
    wr(6'd32, 8'h11, 4, 0);
    wr(6'd33, 8'h22, 4, 0);
    wr(6'd39, 8'h44, 4, 0);
    wr(6'd34, 8'h83, 4, 0);
    rd(6'd0, q, oe); chk("R7 status from last byte", q, 8'h00);
    cyc(IDLE_WAIT);
    rd(6'd32, q, oe); chk("R7 slot0", q, 8'h11);
    rd(6'd33, q, oe); chk("R7 slot1", q, 8'h22);
    rd(6'd34, q, oe); chk("R7 slot2", q, 8'h83);
    rd(6'd35, q, oe); chk("R7 folded slot3", q, 8'h44);
    rd(6'd39, q, oe); chk("R7 other page untouched", q, 8'hFF);
    rd(6'd36, q, oe); chk("R7 neighbour untouched", q, 8'hFF);
  endtask

  task automatic t_overwrite();
    logic [DW-1:0] q; logic oe;
    wr(6'd40, 8'h01, 4, 0);
    wr(6'd40, 8'h02, 4, 0);
    cyc(IDLE_WAIT);
    rd(6'd40, q, oe); chk("R10 last write wins", q, 8'h02);
  endtask

  task automatic t_prog_ignore();
    logic [DW-1:0] q; logic oe;
    wr(6'd48, 8'h66, 4, 0);
    cyc(LOAD_WIN + 10);
    wr(6'd49, 8'h77, 4, 0);
    wr(6'd48, 8'h99, 4, 0);
    rd(6'd48, q, oe); chk("R8 status unchanged", q, 8'h80);
    cyc(IDLE_WAIT);
    rd(6'd48, q, oe); chk("R8 data unchanged", q, 8'h66);
    rd(6'd49, q, oe); chk("R8 ignored byte absent", q, 8'hFF);
  endtask

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc((1 << AW) + 10);
    t_reset();
    t_short();
    t_pwr();
    t_inhibit();
    t_latch();
    t_status();
    t_page();
    t_overwrite();
    t_prog_ignore();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule